// File: doc/BRIEF.md
# Byte-Serial Register Write Receiver

This block turns a stream of bytes on an 8-bit bus into register writes. A sender starts a command by raising a first-byte flag together with the first byte. Five more bytes follow in consecutive clocks. The first two bytes form a 16-bit address and the last four form a 32-bit data word. The receiver compares the address with a configured base address, looking only at the bit positions selected by a mask. When they agree, it raises a write enable for one clock. In that clock it also presents the 32-bit word and a small register index, which the consumer decodes into separate command registers.

The block needs no handshake from the sender. The first-byte flag alone frames each command, so a fresh flag always restarts reception. Bytes that arrive while no command is in progress are dropped.

Top module: `cmd_byte_deser`

## Requirements
- R1: While `rst_n` is low at a clock edge, `wr_en` is 0 after that edge, and `wr_data` and `reg_sel` are 0. A command cut short by reset produces no write.
- R2: The address is built low byte first: the byte that comes with `cmd_first` is address bits [7:0], and the next byte is bits [15:8].
- R3: The four bytes after the address fill `wr_data` from the bottom up. The third byte of the command is bits [7:0] and the sixth byte is bits [31:24].
- R4: `wr_en` is high for exactly one clock, in the cycle right after the edge that captured the sixth byte. There is one pulse per accepted command.
- R5: Address bits where `ADDR_MASK` is 0 do not affect the match. With the default mask 16'hF0FE, bits 11:8 and bit 0 are ignored.
- R6: A command whose address differs from `BASE_ADDR` in any bit where the mask is 1 produces no `wr_en` pulse.
- R7: `reg_sel` equals the low `SEL_W` bits of the received address, which the mask does not cover. With the defaults, address bit 0 gives register index 0 or 1.
- R8: If `cmd_first` rises again before a command is complete, the new byte becomes the address low byte of a new command. The partial command produces no write.
- R9: Bytes on `cmd_byte` while no command is in progress and `cmd_first` is low are ignored: no `wr_en`, and `wr_data` keeps its value.
- R10: A new `cmd_first` may come in the clock right after the sixth byte, which is the `wr_en` cycle. Both commands are then accepted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| cmd_byte | input | 8 | Shared address/data byte bus |
| cmd_first | input | 1 | High with the first (address low) byte of a command |
| reg_sel | output | SEL_W | Register index from the low address bits |
| wr_data | output | DATA_W | Assembled 32-bit data word |
| wr_en | output | 1 | One-clock write strobe for a matched command |

## Verification
A byte counter that is off by one would load the bytes into the wrong lanes. That shows as a wrong `wr_data` or `reg_sel` value, or as `wr_en` one clock early or late, within the first command after the fault. A phase flag stuck in the busy state would turn stray bytes into writes, seen as an extra `wr_en` within six clocks. A wrong match term shows on the first command that touches a masked or unmasked address bit. The bench models the burst framing cycle by cycle and compares `wr_en`, and on every pulse `wr_data` and `reg_sel`, at every clock, so each fault is caught in the cycle it reaches the ports.

// File: rtl/cmdd_pkg.sv
// Package: cmdd_pkg
// Shared byte type and the masked address compare used by the receiver.
// Assumes the serial bus is always one byte wide.
package cmdd_pkg;

    localparam int BYTE_W = 8;

    typedef logic [BYTE_W-1:0] byte_t;

    // True when addr and base agree in every bit position that mask selects.
    function automatic logic masked_equal(input logic [15:0] addr,
                                          input logic [15:0] base,
                                          input logic [15:0] mask);
        return ((addr ^ base) & mask) == 16'h0000;
    endfunction

endpackage

// File: rtl/cmdd_seq.sv
// Module: cmdd_seq
// Tracks the position inside a burst of NB bytes.
// - Raises one lane-load bit per byte.
// - Flags the cycle that carries the last byte.
// Assumes cmd_first always restarts the burst, even in the middle of one.
module cmdd_seq #(
    parameter int NB = 6
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cmd_first,
    output logic [NB-1:0] lane_ld,
    output logic          last,
    output logic          busy
);
    localparam int CNT_W = $clog2(NB);
    localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(NB - 1);

    logic [CNT_W-1:0] cnt_q;
    logic             busy_q;

    // Burst position: a start flag jumps to byte 1, otherwise step until the last byte.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q <= 1'b0;
            cnt_q  <= '0;
        end else if (cmd_first) begin
            busy_q <= 1'b1;
            cnt_q  <= CNT_W'(1);
        end else if (busy_q) begin
            if (cnt_q == LAST_IDX) begin
                busy_q <= 1'b0;
                cnt_q  <= '0;
            end else begin
                cnt_q <= cnt_q + CNT_W'(1);
            end
        end
    end

    // One load enable per byte lane; lane 0 is only ever loaded by the start flag.
    generate
        for (genvar i = 0; i < NB; i++) begin : g_ld
            if (i == 0) begin : g_first
                assign lane_ld[i] = cmd_first;
            end else begin : g_rest
                assign lane_ld[i] = busy_q && !cmd_first && (cnt_q == CNT_W'(i));
            end
        end
    endgenerate

    assign last = busy_q && !cmd_first && (cnt_q == LAST_IDX);
    assign busy = busy_q;

    // R8: a start flag always leaves the sequencer waiting for byte 1
    p_restart_r8: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_first |=> (busy_q && cnt_q == CNT_W'(1)));

    // R8: the position never leaves the burst range
    p_cnt_range_r8: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= LAST_IDX);

    // R2: at most one byte lane is loaded per clock
    p_one_lane_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(lane_ld));

endmodule

// File: rtl/cmdd_lanes.sv
// Module: cmdd_lanes
// Holds one register per burst byte and loads each from the shared bus when told to.
// Assumes the sequencer asserts at most one load bit per clock.
module cmdd_lanes
    import cmdd_pkg::*;
#(
    parameter int NB = 6
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  byte_t                cmd_byte,
    input  logic [NB-1:0]        lane_ld,
    output logic [BYTE_W*NB-1:0] lanes
);
    generate
        for (genvar i = 0; i < NB; i++) begin : g_lane
            byte_t lane_q;

            // Capture the bus byte into this lane when its position comes up.
            always_ff @(posedge clk) begin
                if (!rst_n)          lane_q <= '0;
                else if (lane_ld[i]) lane_q <= cmd_byte;
            end

            assign lanes[BYTE_W*i +: BYTE_W] = lane_q;
        end
    endgenerate

endmodule

// File: rtl/cmdd_match.sv
// Module: cmdd_match
// Compares the assembled address with the base under the mask.
// Extracts the register index from the low address bits.
// Assumes the mask leaves the low SEL_W bits clear.
module cmdd_match
    import cmdd_pkg::*;
#(
    parameter int          ADDR_W    = 16,
    parameter int          SEL_W     = 1,
    parameter logic [15:0] BASE_ADDR = 16'h0480,
    parameter logic [15:0] ADDR_MASK = 16'hF0FE
) (
    input  logic [ADDR_W-1:0] addr,
    output logic              hit,
    output logic [SEL_W-1:0]  sel
);
    // Masked compare of the received address against the base.
    always_comb begin
        hit = masked_equal(addr, BASE_ADDR, ADDR_MASK);
        sel = addr[SEL_W-1:0];
    end

endmodule

// File: rtl/cmd_byte_deser.sv
// Module: cmd_byte_deser
// Receives six-byte write commands framed by a first-byte flag.
// - Bytes 0 and 1 form the address, low byte first.
// - Bytes 2 to 5 form the data word, least significant byte first.
// - A masked address match yields a one-clock write strobe with the data and register index.
// Assumes ADDR_W is 16 and DATA_W is a multiple of 8.
module cmd_byte_deser
    import cmdd_pkg::*;
#(
    parameter int          ADDR_W    = 16,
    parameter int          DATA_W    = 32,
    parameter int          SEL_W     = 1,
    parameter logic [15:0] BASE_ADDR = 16'h0480,
    parameter logic [15:0] ADDR_MASK = 16'hF0FE
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [7:0]        cmd_byte,
    input  logic              cmd_first,
    output logic [SEL_W-1:0]  reg_sel,
    output logic [DATA_W-1:0] wr_data,
    output logic              wr_en
);
    localparam int A_LANES = ADDR_W / BYTE_W;
    localparam int D_LANES = DATA_W / BYTE_W;
    localparam int NB      = A_LANES + D_LANES;

    logic [NB-1:0]        lane_ld;
    logic                 last;
    logic                 busy;
    logic [BYTE_W*NB-1:0] lanes;
    logic [ADDR_W-1:0]    addr;
    logic                 hit;
    logic                 wr_en_q;

    cmdd_seq #(.NB(NB)) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .cmd_first (cmd_first),
        .lane_ld   (lane_ld),
        .last      (last),
        .busy      (busy)
    );

    cmdd_lanes #(.NB(NB)) u_lanes (
        .clk      (clk),
        .rst_n    (rst_n),
        .cmd_byte (cmd_byte),
        .lane_ld  (lane_ld),
        .lanes    (lanes)
    );

    assign addr    = lanes[ADDR_W-1:0];
    assign wr_data = lanes[BYTE_W*NB-1 -: DATA_W];

    cmdd_match #(
        .ADDR_W    (ADDR_W),
        .SEL_W     (SEL_W),
        .BASE_ADDR (BASE_ADDR),
        .ADDR_MASK (ADDR_MASK)
    ) u_match (
        .addr (addr),
        .hit  (hit),
        .sel  (reg_sel)
    );

    // Write strobe: registered one clock after the last byte, only on an address hit.
    always_ff @(posedge clk) begin
        if (!rst_n) wr_en_q <= 1'b0;
        else        wr_en_q <= last && hit;
    end

    assign wr_en = wr_en_q;

    // R1: reset leaves the strobe low
    p_reset_quiet_r1: assert property (@(posedge clk)
        !rst_n |=> !wr_en);

    // R4: the strobe lasts a single clock
    p_we_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> !wr_en);

    // R6: a strobe is only seen with a matching address on the lanes
    p_we_hit_r6: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> hit);

    // R9: an idle clock without a start flag gives no strobe
    p_idle_no_we_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !cmd_first) |=> !wr_en);

    // R9: an idle clock without a start flag leaves the data word untouched
    p_idle_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !cmd_first) |=> $stable(wr_data));

endmodule

// File: tb/cmd_byte_deser_tb.sv
// Bench: cmd_byte_deser_tb
// Behavioural burst model compared with the design on every clock, plus scenario checks.
module cmd_byte_deser_tb;

    localparam logic [15:0] BASE = 16'h0480;
    localparam logic [15:0] MASK = 16'hF0FE;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  cmd_byte = 8'h00;
    logic        cmd_first = 1'b0;
    logic [0:0]  reg_sel;
    logic [31:0] wr_data;
    logic        wr_en;

    int    n_tests = 0;
    int    n_fail = 0;
    int    we_seen = 0;
    bit    done = 1'b0;
    string cur_req = "R1";

    // Reference model state
    int          pos = -1;
    logic [7:0]  bq[$];
    logic        exp_we = 1'b0;
    logic [0:0]  exp_sel = 1'b0;
    logic [31:0] exp_data = 32'h0;

    always #5 clk = ~clk;

    cmd_byte_deser u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .cmd_byte  (cmd_byte),
        .cmd_first (cmd_first),
        .reg_sel   (reg_sel),
        .wr_data   (wr_data),
        .wr_en     (wr_en)
    );

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Behavioural model of the burst framing, evaluated at each rising edge
    always @(posedge clk) begin
        logic [15:0] a;
        exp_we = 1'b0;
        if (!rst_n) begin
            pos = -1;
            bq.delete();
        end else if (cmd_first) begin
            bq.delete();
            bq.push_back(cmd_byte);
            pos = 1;
        end else if (pos > 0) begin
            bq.push_back(cmd_byte);
            if (pos == 5) begin
                a = {bq[1], bq[0]};
                if (((a ^ BASE) & MASK) == 16'h0) begin
                    exp_we   = 1'b1;
                    exp_sel  = a[0];
                    exp_data = {bq[5], bq[4], bq[3], bq[2]};
                end
                pos = -1;
            end else begin
                pos = pos + 1;
            end
        end
    end

    // Per-clock comparison away from the active edge
    always @(negedge clk) begin
        if (wr_en) we_seen++;
        check(wr_en === exp_we, {cur_req, " wr_en"}, {31'b0, wr_en}, {31'b0, exp_we});
        if (exp_we) begin
            check(wr_data === exp_data, {cur_req, " wr_data"}, wr_data, exp_data);
            check(reg_sel === exp_sel, {cur_req, " reg_sel"}, {31'b0, reg_sel}, {31'b0, exp_sel});
        end
    end

    task automatic put(input logic f, input logic [7:0] b);
        @(negedge clk);
        cmd_first = f;
        cmd_byte  = b;
    endtask

    task automatic send(input logic [15:0] a, input logic [31:0] d, input int nbytes);
        logic [7:0] bytes [6];
        bytes[0] = a[7:0];   bytes[1] = a[15:8];
        bytes[2] = d[7:0];   bytes[3] = d[15:8];
        bytes[4] = d[23:16]; bytes[5] = d[31:24];
        for (int i = 0; i < nbytes; i++) put(i == 0, bytes[i]);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) put(1'b0, 8'hA5 + 8'(i));
    endtask

    initial begin
        int base_cnt;
        logic [31:0] held;
        cur_req = "R1";
        repeat (3) @(negedge clk);
        check(wr_en === 1'b0, "R1 wr_en in reset", {31'b0, wr_en}, 32'h0);
        check(wr_data === 32'h0, "R1 wr_data in reset", wr_data, 32'h0);
        check(reg_sel === 1'b0, "R1 reg_sel in reset", {31'b0, reg_sel}, 32'h0);
        rst_n = 1'b1;
        idle(2);

        cur_req = "R2 R3 R4";
        base_cnt = we_seen;
        send(16'h0480, 32'h1234_5678, 6);
        idle(3);
        check(we_seen - base_cnt == 1, "R4 pulse count", 32'(we_seen - base_cnt), 32'd1);
        check(wr_data === 32'h1234_5678, "R3 data order", wr_data, 32'h1234_5678);

        cur_req = "R7";
        send(16'h0481, 32'hCAFE_F00D, 6);
        @(negedge clk);
        check(reg_sel === 1'b1, "R7 select bit", {31'b0, reg_sel}, 32'd1);
        idle(2);

        cur_req = "R5";
        base_cnt = we_seen;
        send(16'h0B80, 32'h0BAD_BEEF, 6);
        idle(3);
        check(we_seen - base_cnt == 1, "R5 masked bits ignored", 32'(we_seen - base_cnt), 32'd1);

        cur_req = "R6";
        base_cnt = we_seen;
        send(16'h1480, 32'h1111_1111, 6);
        idle(2);
        send(16'h0482, 32'h2222_2222, 6);
        idle(3);
        check(we_seen == base_cnt, "R6 mismatch no write", 32'(we_seen - base_cnt), 32'd0);

        cur_req = "R8";
        base_cnt = we_seen;
        send(16'h0480, 32'hDEAD_0000, 4);
        send(16'h0481, 32'h5566_7788, 6);
        idle(3);
        check(we_seen - base_cnt == 1, "R8 restart one write", 32'(we_seen - base_cnt), 32'd1);
        check(wr_data === 32'h5566_7788, "R8 restart data", wr_data, 32'h5566_7788);

        cur_req = "R9";
        base_cnt = we_seen;
        held = wr_data;
        idle(12);
        check(we_seen == base_cnt, "R9 stray bytes no write", 32'(we_seen - base_cnt), 32'd0);
        check(wr_data === held, "R9 data held", wr_data, held);

        cur_req = "R10";
        base_cnt = we_seen;
        send(16'h0480, 32'hAAAA_0001, 6);
        send(16'h0481, 32'hBBBB_0002, 6);
        idle(3);
        check(we_seen - base_cnt == 2, "R10 back-to-back", 32'(we_seen - base_cnt), 32'd2);

        cur_req = "R1";
        base_cnt = we_seen;
        send(16'h0480, 32'h7777_7777, 3);
        @(negedge clk);
        rst_n = 1'b0;
        cmd_first = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        idle(6);
        check(we_seen == base_cnt, "R1 reset aborts command", 32'(we_seen - base_cnt), 32'd0);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    // Watchdog: a hung run counts as a failure
    initial begin
        #1_000_000;
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

endmodule